// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of sixteen general-purpose pins, controlled through a small synchronous register port: an address, a write enable, write data, and combinational read data. Each pin can be an input or an output. When it is an output, it drives the value held in an output data register. It can also be handed to an alternate function through a select output; the alternate logic and the pad drivers sit outside the block. Several identical banks can sit side by side in a larger controller, at evenly spaced base addresses.

Each pin can raise an interrupt. Three control registers set the detection for each pin independently:
- one bit picks edge or level detection;
- for edge pins, one bit picks rising or falling;
- for level pins, one bit picks active-high or active-low.

Pin inputs pass through a two-flop synchroniser. An edge is found by comparing the synchronised value with its value one cycle earlier. Detected events latch into a sticky status register. Writing an all-zero word to that register clears it. The status bits that are not masked are ORed into one bank interrupt line.

Top module: `gpio_bank`

Register offsets (4-bit address): 0x0 pin input level (read-only), 0x1 output data, 0x2 direction, 0x3 alternate select, 0x4 interrupt mask, 0x5 trigger type, 0x6 edge polarity, 0x7 level polarity, 0x8 interrupt status. Every other offset reads as zero and ignores writes.

## Requirements
- R1: While reset is held, every register reads zero except the interrupt mask, which reads 0xFFFF, and irqOut is 0.
- R2: The output data, direction and alternate select registers read back what was written and drive pinOut, pinOutEn and altSel on the cycle after the write. A direction bit of 1 makes that pin an output and a bit of 0 makes it an input.
- R3: Offset 0x0 returns the pin inputs after a two-flop synchroniser. A change applied just after clock edge k is still hidden between edges k+1 and k+2, and is visible after edge k+2.
- R4: A pin with trigger-type bit 1 is edge-detected. With edge-polarity bit 1 it latches its status bit on a rising input, after the third clock edge following the change, and it ignores a falling input.
- R5: An edge pin with edge-polarity bit 0 latches on a falling input and ignores a rising input.
- R6: A pin with trigger-type bit 0 is level-detected. Its status bit is set on every cycle that the synchronised input equals its level-polarity bit (1 means high, 0 means low), so a clear while the condition holds leaves the bit set.
- R7: Writing 0x0000 to offset 0x8 clears every status bit whose pin has no new event in that cycle. Writing any non-zero value to offset 0x8 leaves the status unchanged.
- R8: If an edge event is detected in the same cycle as a clearing write, that status bit stays set.
- R9: irqOut is 1 exactly when some status bit is set whose mask bit is 0. A mask bit of 1 blocks only the interrupt line; the status bit still latches.
- R10: Writes to offset 0x0 and to unmapped offsets change no register, and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Register offset for reads and writes |
| regWrEn | input | 1 | Write strobe, sampled at the clock edge |
| regWrData | input | WIDTH | Write data |
| regRdData | output | WIDTH | Read data for regAddr (combinational) |
| pinIn | input | WIDTH | Asynchronous pin inputs |
| pinOut | output | WIDTH | Output data towards the pads |
| pinOutEn | output | WIDTH | Per-pin output enable (1 = output) |
| altSel | output | WIDTH | Per-pin alternate function select |
| irqOut | output | 1 | Bank interrupt, OR of unmasked status bits |

## Verification
The bench tests the clearing write against a level condition that still holds, and against an edge that lands on the same cycle. A design where the clear has priority would drop these events. It checks the exact synchroniser latency by reading the pin level and the status both one cycle before and on the cycle they should change, so a missing or extra flop shows up. It drives each edge pin in its unselected direction to catch a detector that fires on both edges. It also checks that masked pins still latch status while the interrupt line stays low, and that non-zero writes to the status register and writes to the read-only or unmapped offsets leave the state untouched.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_PIN  = 4'h0,
    REG_OUT  = 4'h1,
    REG_DIR  = 4'h2,
    REG_ALT  = 4'h3,
    REG_MASK = 4'h4,
    REG_TRIG = 4'h5,
    REG_EDGE = 4'h6,
    REG_LVL  = 4'h7,
    REG_STAT = 4'h8
  } regSel_e;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic    wrOut;
    logic    wrDir;
    logic    wrAlt;
    logic    wrMask;
    logic    wrTrig;
    logic    wrEdge;
    logic    wrLvl;
    logic    clrStat;
    logic    rdValid;
    regSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [WIDTH-1:0]  regWrData,
  output ctrlStrobe_t       strobe
);

  logic wrZero;
  assign wrZero = (regWrData == '0);

  always_comb begin
    strobe         = '0;
    strobe.rdSel   = REG_PIN;
    strobe.rdValid = 1'b1;
    case (regAddr)
      REG_PIN:  strobe.rdSel = REG_PIN;
      REG_OUT:  begin strobe.rdSel = REG_OUT;  strobe.wrOut  = regWrEn; end
      REG_DIR:  begin strobe.rdSel = REG_DIR;  strobe.wrDir  = regWrEn; end
      REG_ALT:  begin strobe.rdSel = REG_ALT;  strobe.wrAlt  = regWrEn; end
      REG_MASK: begin strobe.rdSel = REG_MASK; strobe.wrMask = regWrEn; end
      REG_TRIG: begin strobe.rdSel = REG_TRIG; strobe.wrTrig = regWrEn; end
      REG_EDGE: begin strobe.rdSel = REG_EDGE; strobe.wrEdge = regWrEn; end
      REG_LVL:  begin strobe.rdSel = REG_LVL;  strobe.wrLvl  = regWrEn; end
      REG_STAT: begin
        strobe.rdSel   = REG_STAT;
        // only an all-zero word clears; other values are dropped
        strobe.clrStat = regWrEn & wrZero;
      end
      default:  strobe.rdValid = 1'b0;
    endcase
  end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '0;
        else       chain[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '0;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign syncOut = chain[LAST];

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_bank_pkg::*;
#(
  parameter int               WIDTH    = 16,
  parameter logic [WIDTH-1:0] MASK_RST = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] pinSync,
  output logic [WIDTH-1:0] outReg,
  output logic [WIDTH-1:0] dirReg,
  output logic [WIDTH-1:0] altReg,
  output logic [WIDTH-1:0] maskReg,
  output logic [WIDTH-1:0] statusVec,
  output logic [WIDTH-1:0] rdData
);

  logic [WIDTH-1:0] trigReg;
  logic [WIDTH-1:0] edgeReg;
  logic [WIDTH-1:0] lvlReg;
  logic [WIDTH-1:0] pinPrev;
  logic [WIDTH-1:0] hitVec;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg  <= '0;
      dirReg  <= '0;
      altReg  <= '0;
      maskReg <= MASK_RST;
      trigReg <= '0;
      edgeReg <= '0;
      lvlReg  <= '0;
    end else begin
      if (strobe.wrOut)  outReg  <= wrData;
      if (strobe.wrDir)  dirReg  <= wrData;
      if (strobe.wrAlt)  altReg  <= wrData;
      if (strobe.wrMask) maskReg <= wrData;
      if (strobe.wrTrig) trigReg <= wrData;
      if (strobe.wrEdge) edgeReg <= wrData;
      if (strobe.wrLvl)  lvlReg  <= wrData;
    end
  end

  // previous synchronised value for edge finding
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinSync;
  end

  // per-pin event detection
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic riseSeen;
    logic fallSeen;
    logic edgeHit;
    logic levelHit;
    assign riseSeen = pinSync[i] & ~pinPrev[i];
    assign fallSeen = ~pinSync[i] & pinPrev[i];
    assign edgeHit  = edgeReg[i] ? riseSeen : fallSeen;
    assign levelHit = ~(pinSync[i] ^ lvlReg[i]);
    assign hitVec[i] = trigReg[i] ? edgeHit : levelHit;
  end

  // sticky status, new events win over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusVec <= '0;
    else       statusVec <= (strobe.clrStat ? '0 : statusVec) | hitVec;
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdValid) begin
      case (strobe.rdSel)
        REG_PIN:  rdData = pinSync;
        REG_OUT:  rdData = outReg;
        REG_DIR:  rdData = dirReg;
        REG_ALT:  rdData = altReg;
        REG_MASK: rdData = maskReg;
        REG_TRIG: rdData = trigReg;
        REG_EDGE: rdData = edgeReg;
        REG_LVL:  rdData = lvlReg;
        REG_STAT: rdData = statusVec;
        default:  rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter int SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [WIDTH-1:0]  regWrData,
  output logic [WIDTH-1:0]  regRdData,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinOutEn,
  output logic [WIDTH-1:0]  altSel,
  output logic              irqOut
);

  ctrlStrobe_t      strobe;
  logic [WIDTH-1:0] pinSync;
  logic [WIDTH-1:0] maskReg;
  logic [WIDTH-1:0] statusVec;

  gpio_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .strobe    (strobe)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_LEN)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinIn),
    .syncOut (pinSync)
  );

  gpio_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (regWrData),
    .pinSync   (pinSync),
    .outReg    (pinOut),
    .dirReg    (pinOutEn),
    .altReg    (altSel),
    .maskReg   (maskReg),
    .statusVec (statusVec),
    .rdData    (regRdData)
  );

  assign irqOut = |(statusVec & ~maskReg);

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [WIDTH-1:0]  regWrData,
  input logic [WIDTH-1:0]  pinOut,
  input logic [WIDTH-1:0]  pinOutEn,
  input logic [WIDTH-1:0]  altSel,
  input logic [WIDTH-1:0]  maskReg,
  input logic [WIDTH-1:0]  statusVec,
  input logic              irqOut
);

  logic clearWrite;
  logic dirWrite;
  logic roWrite;
  assign clearWrite = regWrEn && (regAddr == REG_STAT) && (regWrData == '0);
  assign dirWrite   = regWrEn && (regAddr == REG_DIR);
  assign roWrite    = regWrEn && (regAddr == REG_PIN);

  p_reset_mask_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (maskReg == '1));

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    dirWrite |=> (pinOutEn == $past(regWrData)));

  p_sticky_status_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((|($past(statusVec) & ~statusVec)) && $past(rstN)) |-> $past(clearWrite));

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (statusVec != '0));

  p_readonly_pin_r10: assert property (@(posedge clk) disable iff (!rstN)
    roWrite |=> ($stable(pinOut) && $stable(pinOutEn) && $stable(altSel)
                 && $stable(maskReg)));

endmodule

bind gpio_bank gpio_bank_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .pinOut    (pinOut),
  .pinOutEn  (pinOutEn),
  .altSel    (altSel),
  .maskReg   (maskReg),
  .statusVec (statusVec),
  .irqOut    (irqOut)
);

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  localparam int K_RD   = 0;
  localparam int K_IRQ  = 1;
  localparam int K_OUT  = 2;
  localparam int K_OE   = 3;
  localparam int K_ALT  = 4;

  localparam logic [3:0] A_PIN  = 4'h0;
  localparam logic [3:0] A_OUT  = 4'h1;
  localparam logic [3:0] A_DIR  = 4'h2;
  localparam logic [3:0] A_ALT  = 4'h3;
  localparam logic [3:0] A_MASK = 4'h4;
  localparam logic [3:0] A_TRIG = 4'h5;
  localparam logic [3:0] A_EDGE = 4'h6;
  localparam logic [3:0] A_LVL  = 4'h7;
  localparam logic [3:0] A_STAT = 4'h8;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    int          req;
  } item_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [3:0]    regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [W-1:0]  regWrData = '0;
  logic [W-1:0]  regRdData;
  logic [W-1:0]  pinIn = '0;
  logic [W-1:0]  pinOut;
  logic [W-1:0]  pinOutEn;
  logic [W-1:0]  altSel;
  logic          irqOut;

  int checks = 0;
  int fails  = 0;
  item_t expQ[$];
  item_t cur;
  logic [15:0] act;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOutEn(pinOutEn), .altSel(altSel), .irqOut(irqOut)
  );

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      cur = expQ.pop_front();
      case (cur.kind)
        K_RD:    act = regRdData;
        K_IRQ:   act = {15'b0, irqOut};
        K_OUT:   act = pinOut;
        K_OE:    act = pinOutEn;
        default: act = altSel;
      endcase
      checks++;
      if (act !== cur.exp) begin
        fails++;
        $display("FAIL R%0d kind %0d: actual %h expected %h", cur.req,
                 cur.kind, act, cur.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  // push an expectation for the current cycle, then move one cycle on
  task automatic expectK(input int kind, input logic [15:0] e, input int req);
    item_t it;
    it.kind = kind; it.exp = e; it.req = req;
    expQ.push_back(it);
    tick();
  endtask

  task automatic expectRd(input logic [3:0] a, input logic [15:0] e, input int req);
    regAddr = a;
    expectK(K_RD, e, req);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      finishRun();
    end
  end

  initial begin
    // R1: reset values while reset held
    tick();
    expectRd(A_PIN,  16'h0000, 1);
    expectRd(A_OUT,  16'h0000, 1);
    expectRd(A_DIR,  16'h0000, 1);
    expectRd(A_ALT,  16'h0000, 1);
    expectRd(A_MASK, 16'hFFFF, 1);
    expectRd(A_TRIG, 16'h0000, 1);
    expectRd(A_EDGE, 16'h0000, 1);
    expectRd(A_LVL,  16'h0000, 1);
    expectRd(A_STAT, 16'h0000, 1);
    expectK(K_IRQ, 16'h0000, 1);
    rstN = 1'b1;
    tick();

    // all pins edge mode, then wipe status left by level-low default
    wr(A_TRIG, 16'hFFFF);
    wr(A_STAT, 16'h0000);
    expectRd(A_STAT, 16'h0000, 7);

    // R2: output-side registers
    wr(A_DIR, 16'hA5A5);
    expectRd(A_DIR, 16'hA5A5, 2);
    expectK(K_OE, 16'hA5A5, 2);
    wr(A_OUT, 16'h3C3C);
    expectK(K_OUT, 16'h3C3C, 2);
    wr(A_ALT, 16'h0F0F);
    expectK(K_ALT, 16'h0F0F, 2);

    // R10: read-only and unmapped offsets
    wr(A_PIN, 16'hFFFF);
    expectRd(A_PIN, 16'h0000, 10);
    expectK(K_OUT, 16'h3C3C, 10);
    wr(4'hF, 16'h1234);
    expectRd(4'hF, 16'h0000, 10);
    expectK(K_OE, 16'hA5A5, 10);

    // pins 0,1 rising; rest falling
    wr(A_EDGE, 16'h0003);

    // R3 and R4: synchroniser latency and rising detection
    pinIn = 16'h0001;
    tick();
    expectRd(A_PIN, 16'h0000, 3);
    expectRd(A_PIN, 16'h0001, 3);
    expectRd(A_STAT, 16'h0001, 4);
    wr(A_STAT, 16'h0000);
    // R4: falling input on a rising-only pin ignored
    pinIn = 16'h0000;
    repeat (4) tick();
    expectRd(A_STAT, 16'h0000, 4);

    // R5: pin 2 falling only; rising is ignored
    pinIn = 16'h0004;
    repeat (4) tick();
    expectRd(A_STAT, 16'h0000, 5);
    pinIn = 16'h0000;
    tick();
    tick();
    expectRd(A_STAT, 16'h0000, 5);
    expectRd(A_STAT, 16'h0004, 5);

    // R7: non-zero write ignored, zero write clears
    wr(A_STAT, 16'hFFFF);
    expectRd(A_STAT, 16'h0004, 7);
    wr(A_STAT, 16'h0000);
    expectRd(A_STAT, 16'h0000, 7);

    // R6: pin 8 level-high, pin 9 level-low
    wr(A_LVL, 16'h0100);
    wr(A_TRIG, 16'hFCFF);
    wr(A_STAT, 16'h0000);
    expectRd(A_STAT, 16'h0200, 6);
    pinIn = 16'h0300;
    repeat (3) tick();
    wr(A_STAT, 16'h0000);
    expectRd(A_STAT, 16'h0100, 6);

    // R8: rising edge on pin 0 meets the clearing write
    pinIn = 16'h0301;
    tick();
    tick();
    wr(A_STAT, 16'h0000);
    expectRd(A_STAT, 16'h0101, 8);
    wr(A_STAT, 16'h0000);
    expectRd(A_STAT, 16'h0100, 8);

    // R9: masking blocks irq but not status
    expectK(K_IRQ, 16'h0000, 9);
    wr(A_MASK, 16'hFEFF);
    expectK(K_IRQ, 16'h0001, 9);
    wr(A_LVL, 16'h0000);
    wr(A_STAT, 16'h0000);
    expectRd(A_STAT, 16'h0000, 9);
    expectK(K_IRQ, 16'h0000, 9);

    tick();
    done = 1'b1;
    finishRun();
  end

endmodule